// File: doc/BRIEF.md
# Top-Down Pipeline Slot Accounting Unit

This unit sorts the issue slots of a superscalar pipeline into four classes and keeps one running total per class. Each cycle it is told three things: how many micro-ops the decode queue failed to hand to allocation, how many were allocated, and how many retired. A fourth input marks a mispredict recovery. A fixed slot width `W` sets how many slots each cycle offers. Beside the four class totals, the unit also keeps a cycle count and a total-slot count, so software can turn each class into a fraction of the available slots.

Front-end-bound slots are the undelivered micro-ops. Retiring slots are the retired micro-ops. Bad-speculation slots are the allocated micro-ops that did not retire, plus a fixed recovery charge of `PEN_CYC` cycles' worth of slots for every recovery cycle. Back-end-bound slots are whatever remains of the total once the other three classes are removed. All totals share one enable and one clear. A programmable window length stops the measurement and raises a one-cycle ready pulse.

The controller is a three-state machine. `S_IDLE` means the unit is cleared and nothing has been counted. `S_COUNT` means a window is open. `S_HOLD` means the window is complete and the totals are frozen. It has four transitions:
- IDLE to COUNT on the first enabled cycle.
- IDLE to HOLD when that first cycle already completes the window.
- COUNT to HOLD when the cycle count reaches the window length.
- Any state to IDLE on clear.

Top module: `tda_slot_acct`

## Requirements
- R1: After reset, and in the cycle after `acc_clr` is high, every counter output reads 0 and `sample_rdy` is 0. `acc_clr` wins over `acc_en` in the same cycle.
- R2: Each counted cycle (`acc_en` high, no clear, not frozen) adds 1 to `cyc_cnt` and `W` (default 4) to `tot_slots`.
- R3: Each counted cycle adds min(`undeliv`, W) to `fe_slots`.
- R4: Each counted cycle adds min(`retire_n`, W) to `ret_slots`.
- R5: `bs_slots` equals the sum of min(`alloc_n`, W), plus `PEN_CYC`·W (default 80) for each counted cycle with `flush` high, minus `ret_slots`. It reads 0 when that value would be negative.
- R6: `be_slots` equals `tot_slots` − `fe_slots` − `bs_slots` − `ret_slots`, and reads 0 when that value would be negative.
- R7: With `win_len` nonzero, the counted cycle that brings `cyc_cnt` to `win_len` is the last one counted. `sample_rdy` is high for exactly the following cycle. All counters then hold until a clear. With `win_len` = 0 there is no window.
- R8: A cycle with `acc_en` low changes no output, whatever the slot inputs carry.
- R9: After a clear, counting restarts from zero. This holds whether the clear came during a window or after it completed (IDLE→COUNT→HOLD→IDLE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Count this cycle |
| acc_clr | input | 1 | Synchronous clear of all counters |
| win_len | input | ACC_W | Window length in cycles, 0 = unbounded |
| undeliv | input | SLOT_W | Micro-ops the decode queue failed to deliver |
| alloc_n | input | SLOT_W | Micro-ops allocated |
| retire_n | input | SLOT_W | Micro-ops retired |
| flush | input | 1 | Mispredict recovery cycle |
| cyc_cnt | output | ACC_W | Counted cycles |
| tot_slots | output | ACC_W | Available slots (W per counted cycle) |
| fe_slots | output | ACC_W | Front-end-bound slots |
| be_slots | output | ACC_W | Back-end-bound slots |
| bs_slots | output | ACC_W | Bad-speculation slots |
| ret_slots | output | ACC_W | Retiring slots |
| sample_rdy | output | 1 | One-cycle pulse when the window completes |

## Verification
A full sweep drives every combination of the three slot counts from 0 to 7, including values above W, with a recovery cycle every 37 steps. This separates the clamping of each input from the way it is accumulated.

A run where retirement outpaces allocation, with a large undelivered count, reaches both the bad-speculation floor and the back-end floor.

Cycles with the enable low carry busy inputs, which shows that those inputs are ignored. A clear given together with the enable shows that the clear takes priority. Windows of length 5 and 1 place the ready pulse exactly and show that the totals freeze afterwards.

// File: rtl/tda_pkg.sv
package tda_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_COUNT = 2'd1,
        S_HOLD  = 2'd2
    } tda_state_e;

    localparam int LN_CYC   = 0;
    localparam int LN_TOT   = 1;
    localparam int LN_FE    = 2;
    localparam int LN_ALLOC = 3;
    localparam int LN_RET   = 4;
    localparam int LN_PEN   = 5;
    localparam int LN_NUM   = 6;
endpackage

// File: rtl/tda_accum.sv
module tda_accum #(
    parameter int ACC_W = 32,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             go,
    input  logic [INC_W-1:0] inc,
    output logic [ACC_W-1:0] val
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            val <= '0;
        else if (clr)
            val <= '0;
        else if (go)
            val <= val + ACC_W'(inc);
    end
endmodule

// File: rtl/tda_ctrl.sv
module tda_ctrl
    import tda_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [ACC_W-1:0] win_len,
    input  logic [ACC_W-1:0] cyc_now,
    output logic             acc_go,
    output logic             sample_rdy,
    output tda_state_e       state
);
    tda_state_e state_nxt;
    logic       win_hit;

    always_comb begin
        acc_go    = en && !clr && (state != S_HOLD);
        win_hit   = acc_go && (win_len != '0) && ((cyc_now + 1'b1) == win_len);
        state_nxt = state;
        if (clr) begin
            state_nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  if (en) state_nxt = win_hit ? S_HOLD : S_COUNT;
                S_COUNT: if (win_hit) state_nxt = S_HOLD;
                S_HOLD:  state_nxt = S_HOLD;
                default: state_nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sample_rdy <= 1'b0;
        else        sample_rdy <= win_hit;
    end

    p_rdy_in_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_rdy |-> (state == S_HOLD));
    p_rdy_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_rdy |=> !sample_rdy);
    p_clr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state == S_IDLE) && !sample_rdy);
endmodule

// File: rtl/tda_derive.sv
module tda_derive #(
    parameter int ACC_W = 32
) (
    input  logic [ACC_W-1:0] tot,
    input  logic [ACC_W-1:0] fe,
    input  logic [ACC_W-1:0] alloc,
    input  logic [ACC_W-1:0] ret,
    input  logic [ACC_W-1:0] pen,
    output logic [ACC_W-1:0] bs,
    output logic [ACC_W-1:0] be
);
    localparam int XW = ACC_W + 2;
    logic [XW-1:0] spec_raw, used;

    always_comb begin
        spec_raw = XW'(alloc) + XW'(pen);
        bs       = (spec_raw > XW'(ret)) ? ACC_W'(spec_raw - XW'(ret)) : '0;
        used     = XW'(fe) + XW'(bs) + XW'(ret);
        be       = (XW'(tot) > used) ? ACC_W'(XW'(tot) - used) : '0;
    end
endmodule

// File: rtl/tda_slot_acct.sv
module tda_slot_acct
    import tda_pkg::*;
#(
    parameter int W       = 4,
    parameter int PEN_CYC = 20,
    parameter int ACC_W   = 32,
    localparam int SLOT_W = $clog2(W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_clr,
    input  logic [ACC_W-1:0]  win_len,
    input  logic [SLOT_W-1:0] undeliv,
    input  logic [SLOT_W-1:0] alloc_n,
    input  logic [SLOT_W-1:0] retire_n,
    input  logic              flush,
    output logic [ACC_W-1:0]  cyc_cnt,
    output logic [ACC_W-1:0]  tot_slots,
    output logic [ACC_W-1:0]  fe_slots,
    output logic [ACC_W-1:0]  be_slots,
    output logic [ACC_W-1:0]  bs_slots,
    output logic [ACC_W-1:0]  ret_slots,
    output logic              sample_rdy
);
    localparam int PEN_SLOTS = PEN_CYC * W;
    localparam int INC_W     = $clog2(PEN_SLOTS + W + 1);
    localparam logic [SLOT_W-1:0] WMAX = SLOT_W'(W);

    logic             acc_go;
    tda_state_e       st;
    logic [INC_W-1:0] inc_v [LN_NUM];
    logic [ACC_W-1:0] acc_v [LN_NUM];
    logic [ACC_W-1:0] alloc_sum, pen_sum;

    always_comb begin
        inc_v[LN_CYC]   = INC_W'(1);
        inc_v[LN_TOT]   = INC_W'(W);
        inc_v[LN_FE]    = INC_W'((undeliv  > WMAX) ? WMAX : undeliv);
        inc_v[LN_ALLOC] = INC_W'((alloc_n  > WMAX) ? WMAX : alloc_n);
        inc_v[LN_RET]   = INC_W'((retire_n > WMAX) ? WMAX : retire_n);
        inc_v[LN_PEN]   = flush ? INC_W'(PEN_SLOTS) : '0;
    end

    tda_ctrl #(.ACC_W(ACC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en),
        .win_len(win_len), .cyc_now(acc_v[LN_CYC]),
        .acc_go(acc_go), .sample_rdy(sample_rdy), .state(st)
    );

    for (genvar g = 0; g < LN_NUM; g++) begin : g_lane
        tda_accum #(.ACC_W(ACC_W), .INC_W(INC_W)) u_acc (
            .clk(clk), .rst_n(rst_n), .clr(acc_clr), .go(acc_go),
            .inc(inc_v[g]), .val(acc_v[g])
        );
    end

    assign cyc_cnt   = acc_v[LN_CYC];
    assign tot_slots = acc_v[LN_TOT];
    assign fe_slots  = acc_v[LN_FE];
    assign alloc_sum = acc_v[LN_ALLOC];
    assign ret_slots = acc_v[LN_RET];
    assign pen_sum   = acc_v[LN_PEN];

    tda_derive #(.ACC_W(ACC_W)) u_derive (
        .tot(tot_slots), .fe(fe_slots), .alloc(alloc_sum), .ret(ret_slots),
        .pen(pen_sum), .bs(bs_slots), .be(be_slots)
    );

    p_tot_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tot_slots == ACC_W'(cyc_cnt * W));
    p_fe_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_clr |=> (fe_slots - $past(fe_slots)) <= ACC_W'(W));
    p_ret_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_clr |=> (ret_slots - $past(ret_slots)) <= ACC_W'(W));
    p_partition_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (be_slots != '0) |->
        ((ACC_W+2)'(be_slots) + (ACC_W+2)'(fe_slots) + (ACC_W+2)'(bs_slots)
         + (ACC_W+2)'(ret_slots)) == (ACC_W+2)'(tot_slots));
    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HOLD && !acc_clr) |=> $stable(cyc_cnt) && $stable(fe_slots));
    p_en_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !acc_clr) |=> $stable(tot_slots) && $stable(ret_slots));
    p_clr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (cyc_cnt == '0) && (fe_slots == '0) && (bs_slots == '0));
endmodule

// File: tb/tb_tda_slot_acct.sv
module tb_tda_slot_acct;
    localparam int W = 4;
    localparam int PEN_CYC = 20;
    localparam int ACC_W = 32;
    localparam int SW = $clog2(W + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_en = 1'b0, acc_clr = 1'b0, flush = 1'b0;
    logic [ACC_W-1:0] win_len = '0;
    logic [SW-1:0] undeliv = '0, alloc_n = '0, retire_n = '0;
    logic [ACC_W-1:0] cyc_cnt, tot_slots, fe_slots, be_slots, bs_slots, ret_slots;
    logic sample_rdy;

    int n_chk = 0, n_bad = 0;
    longint m_cyc, m_tot, m_fe, m_al, m_re, m_pn;
    bit m_hold, m_rdy;

    always #2 clk = ~clk;

    tda_slot_acct #(.W(W), .PEN_CYC(PEN_CYC), .ACC_W(ACC_W)) dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_clr(acc_clr),
        .win_len(win_len), .undeliv(undeliv), .alloc_n(alloc_n),
        .retire_n(retire_n), .flush(flush), .cyc_cnt(cyc_cnt),
        .tot_slots(tot_slots), .fe_slots(fe_slots), .be_slots(be_slots),
        .bs_slots(bs_slots), .ret_slots(ret_slots), .sample_rdy(sample_rdy)
    );

    function automatic longint mn(longint v);
        return (v > W) ? W : v;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all();
        longint e_bs, e_be, used;
        e_bs = (m_al + m_pn > m_re) ? (m_al + m_pn - m_re) : 0;
        used = m_fe + e_bs + m_re;
        e_be = (m_tot > used) ? (m_tot - used) : 0;
        chk("R2 cyc_cnt", cyc_cnt, m_cyc);
        chk("R2 tot_slots", tot_slots, m_tot);
        chk("R3 fe_slots", fe_slots, m_fe);
        chk("R4 ret_slots", ret_slots, m_re);
        chk("R5 bs_slots", bs_slots, e_bs);
        chk("R6 be_slots", be_slots, e_be);
        chk("R7 sample_rdy", sample_rdy, m_rdy);
    endtask

    task automatic step(int u, int a, int r, bit f, bit e, bit c);
        undeliv = SW'(u); alloc_n = SW'(a); retire_n = SW'(r);
        flush = f; acc_en = e; acc_clr = c;
        m_rdy = 0;
        if (c) begin
            m_cyc = 0; m_tot = 0; m_fe = 0; m_al = 0; m_re = 0; m_pn = 0; m_hold = 0;
        end else if (e && !m_hold) begin
            m_cyc++; m_tot += W; m_fe += mn(u); m_al += mn(a); m_re += mn(r);
            if (f) m_pn += PEN_CYC * W;
            if (win_len != 0 && m_cyc == longint'(win_len)) begin
                m_hold = 1; m_rdy = 1;
            end
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        m_cyc = 0; m_tot = 0; m_fe = 0; m_al = 0; m_re = 0; m_pn = 0;
        m_hold = 0; m_rdy = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all();
        rst_n = 1'b1;
        @(negedge clk);
        check_all();
        // R2..R5: full sweep of slot inputs including out-of-range values
        for (int i = 0; i < 512; i++)
            step(i % 8, (i / 8) % 8, (i / 64) % 8, (i % 37) == 0, 1'b1, 1'b0);
        // R8: enable low with busy inputs changes nothing
        for (int i = 0; i < 6; i++) step(7, 7, 7, 1'b1, 1'b0, 1'b0);
        // R1: clear wins over enable
        step(3, 3, 3, 1'b1, 1'b1, 1'b1);
        // R5, R6: floors at zero (retire exceeds allocate)
        for (int i = 0; i < 5; i++) step(3, 0, 4, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step(0, 4, 0, 1'b0, 1'b1, 1'b0);
        // R7, R9: window of 5 cycles, then frozen, then restart
        step(0, 0, 0, 1'b0, 1'b0, 1'b1);
        win_len = 5;
        for (int i = 0; i < 9; i++) step(i % 5, 2, 1, i == 2, 1'b1, 1'b0);
        step(0, 0, 0, 1'b0, 1'b1, 1'b1);
        // R7, R9: window of one cycle goes straight to hold
        win_len = 1;
        for (int i = 0; i < 3; i++) step(1, 3, 2, 1'b0, 1'b1, 1'b0);
        step(0, 0, 0, 1'b0, 1'b0, 1'b1);
        win_len = 0;
        for (int i = 0; i < 4; i++) step(2, 4, 4, 1'b0, 1'b1, 1'b0);
        finish_up();
    end
endmodule